// File: doc/BRIEF.md
# Reorder Buffer with Rename Rollback

This block is the in-order retirement queue of an out-of-order core whose rename stage hands out virtual tags first and binds real storage registers only when a result is written back. Every renamed instruction takes one slot. The slot records whether the instruction writes a logical register, which logical register that is, the virtual tag the register held before this instruction, and the tag this instruction received. When the oldest slot has completed, it retires. Retirement hands the previous tag to the rename map. The map releases that tag together with whatever storage register is bound to it.

A branch misprediction, or an exception on the oldest slot, starts a recovery walk. The walk moves backwards from the youngest slot to the faulting one and treats one slot per cycle. For each slot that has a destination, it emits a rollback command. The command puts the earlier tag back into the map and returns the slot's own tag to the free list, along with that tag's storage register if one is bound. The walk fills in the storage register and bound bit for the restored tag by reading the tag-to-register table through a lookup port. This is needed because storage is bound after rename, so the value held at rename time may be stale. The faulting instruction itself keeps its mapping. Once the walk finishes, the slot after it becomes the new allocation point.

Allocation and retirement are valid/ready streams. Allocation is offered only while `alloc_ready` is high. A retirement offer stays up, with stable data, until `commit_ready` accepts it. The one exception is the cycle a recovery starts: that takes the offer back. Completion, recovery requests and rollback commands are plain single-cycle strobes, and the rename map must accept a rollback command in the cycle it appears.

Top module: `rob_rollback`

## Requirements
- R1: After reset the buffer is empty: `empty`=1, `full`=0, `busy`=0, `alloc_ready`=1, `commit_valid`=0, `rb_valid`=0, and `alloc_idx`=0.
- R2: An allocation is taken when `alloc_valid` and `alloc_ready` are both high. Slots are handed out in increasing index order, modulo the depth of 16, and `alloc_idx` names the slot that will be taken. After 16 allocations with no retirement, `full`=1 and `alloc_ready`=0, and any further `alloc_valid` is ignored.
- R3: `commit_valid` is high exactly when the buffer is not empty, no walk is running or starting, and the oldest slot is completed without an exception. It carries that slot's destination flag and previous tag. Slots retire in allocation order.
- R4: While `commit_valid` is high and `commit_ready` is low, the offer and its data stay unchanged in the next cycle, unless a recovery starts.
- R5: A recovery starts in any cycle with `busy`=0 in which either `rec_valid` is high (faulting slot `rec_idx`) or the oldest slot is completed with an exception (faulting slot = oldest). In that cycle, and in every cycle while `busy`=1, `alloc_ready` and `commit_valid` are low. `busy` is high from the next cycle.
- R6: The walk visits slots from the youngest down to the slot just above the faulting one, one per cycle. It then spends one closing cycle. With k slots younger than the faulting one, `busy` stays high for k+1 cycles.
- R7: For a visited slot with a destination, `rb_valid`=1 and the command fields are filled as follows:
  - `rb_lreg` is the slot's logical register.
  - `rb_map_vpr` is its previous tag, and this tag is presented on `lk_prev_vpr`.
  - `rb_map_pr` and `rb_map_bound` are the lookup results for the previous tag.
  - `rb_free_vpr` is the slot's own tag, which is presented on `lk_own_vpr`.
  - `rb_free_pr` is the lookup result for the own tag, and `rb_free_pr_valid` equals the own tag's bound bit.
- R8: A visited slot without a destination uses its walk cycle with `rb_valid`=0 and `rb_free_pr_valid`=0.
- R9: After the walk, the faulting slot is the youngest entry. The next `alloc_idx` is the faulting index + 1 (mod 16), and occupancy is (faulting − oldest) mod 16 + 1.
- R10: The walk's closing cycle clears the faulting slot's exception flag. After an exception recovery the oldest slot then retires through the normal commit stream.
- R11: `rec_valid` is ignored while `busy`=1.
- R12: A completion strobe (`cmpl_valid`, `cmpl_idx`, `cmpl_exc`) marks the named slot as done, and records the exception flag given with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Allocation offer |
| alloc_ready | output | 1 | Allocation can be taken |
| alloc_has_dst | input | 1 | Instruction writes a logical register |
| alloc_lreg | input | 5 | Destination logical register |
| alloc_prev_vpr | input | 7 | Tag the register held before this instruction |
| alloc_own_vpr | input | 7 | Tag given to this instruction |
| alloc_idx | output | 4 | Slot the next allocation takes |
| cmpl_valid | input | 1 | Completion strobe |
| cmpl_idx | input | 4 | Completed slot |
| cmpl_exc | input | 1 | Completion raised an exception |
| commit_valid | output | 1 | Oldest slot offered for retirement |
| commit_ready | input | 1 | Rename map accepts the retirement |
| commit_has_dst | output | 1 | Retiring slot has a destination |
| commit_prev_vpr | output | 7 | Previous tag to release |
| rec_valid | input | 1 | Misprediction recovery request |
| rec_idx | input | 4 | Faulting slot of the request |
| busy | output | 1 | Recovery walk in progress |
| full | output | 1 | All 16 slots in use |
| empty | output | 1 | No slot in use |
| lk_prev_vpr | output | 7 | Lookup address: restored tag |
| lk_prev_pr | input | 6 | Lookup result: register bound to the restored tag |
| lk_prev_bound | input | 1 | Lookup result: restored tag is bound |
| lk_own_vpr | output | 7 | Lookup address: tag being freed |
| lk_own_pr | input | 6 | Lookup result: register bound to the freed tag |
| lk_own_bound | input | 1 | Lookup result: freed tag is bound |
| rb_valid | output | 1 | Rollback command |
| rb_lreg | output | 5 | Logical register to restore |
| rb_map_vpr | output | 7 | Tag written back into the map |
| rb_map_pr | output | 6 | Register written back into the map |
| rb_map_bound | output | 1 | Bound bit written back into the map |
| rb_free_vpr | output | 7 | Tag returned to the free list |
| rb_free_pr | output | 6 | Register returned to the free list |
| rb_free_pr_valid | output | 1 | A register is returned |

## Verification
The hardest situation to reach is an exception on the oldest slot while many younger slots are still in flight. It needs a full buffer, a completion that flags an exception on exactly the oldest index, and a commit stream that is held back until then. The bench reaches it in a directed prelude. First it fills all 16 slots with retirement blocked. Then it requests a misprediction walk in the middle of the buffer, and after that it flags the oldest slot. A long randomised phase follows that wraps the pointers many times. That phase mixes back-pressure, out-of-order completions, recovery requests aimed at random occupied slots including the youngest, and requests issued while a walk is already running.

// File: rtl/rob_pkg.sv
package rob_pkg;
  parameter int ROB_DEPTH = 16;
  parameter int LREG_W    = 5;
  parameter int VPR_W     = 7;
  parameter int PR_W      = 6;
  localparam int ROB_IW   = $clog2(ROB_DEPTH);

  typedef struct packed {
    logic              has_dst;
    logic [LREG_W-1:0] lreg;
    logic [VPR_W-1:0]  prev_vpr;
    logic [VPR_W-1:0]  own_vpr;
  } rob_payload_t;

  typedef enum logic {WALK_IDLE = 1'b0, WALK_RUN = 1'b1} walk_state_t;
endpackage

// File: rtl/rob_entry_store.sv
module rob_entry_store
  import rob_pkg::*;
#(
  parameter int DEPTH = ROB_DEPTH,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  rob_payload_t  wr_data,
  input  logic          set_en,
  input  logic [IW-1:0] set_idx,
  input  logic          set_exc,
  input  logic          clr_en,
  input  logic [IW-1:0] clr_idx,
  input  logic [IW-1:0] rd_a_idx,
  output rob_payload_t  rd_a_data,
  output logic          rd_a_done,
  output logic          rd_a_exc,
  input  logic [IW-1:0] rd_b_idx,
  output rob_payload_t  rd_b_data
);
  rob_payload_t     pay_q [DEPTH];
  logic [DEPTH-1:0] done_q, exc_q;
  logic [DEPTH-1:0] wr_hit, set_hit, clr_hit;

  // one-hot slot selects
  for (genvar g = 0; g < DEPTH; g++) begin : g_sel
    assign wr_hit[g]  = wr_en  && (wr_idx  == IW'(g));
    assign set_hit[g] = set_en && (set_idx == IW'(g));
    assign clr_hit[g] = clr_en && (clr_idx == IW'(g));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (wr_hit[i]) pay_q[i] <= wr_data;
    end
  end

  // allocation clears the flags, completion sets them, the walk's end clears exc
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= '0;
      exc_q  <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (wr_hit[i]) begin
          done_q[i] <= 1'b0;
          exc_q[i]  <= 1'b0;
        end else if (set_hit[i]) begin
          done_q[i] <= 1'b1;
          exc_q[i]  <= set_exc;
        end else if (clr_hit[i]) begin
          exc_q[i]  <= 1'b0;
        end
      end
    end
  end

  assign rd_a_data = pay_q[rd_a_idx];
  assign rd_a_done = done_q[rd_a_idx];
  assign rd_a_exc  = exc_q[rd_a_idx];
  assign rd_b_data = pay_q[rd_b_idx];
endmodule

// File: rtl/rob_ptr_ctrl.sv
module rob_ptr_ctrl #(
  parameter int DEPTH = 16,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic          restore_en,
  input  logic [IW-1:0] restore_fault,
  output logic [IW-1:0] head,
  output logic [IW-1:0] tail,
  output logic          full,
  output logic          empty
);
  logic [IW-1:0] head_q, tail_q;
  logic [IW:0]   cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else if (restore_en) begin
      // faulting slot becomes the youngest entry
      tail_q <= restore_fault + 1'b1;
      cnt_q  <= {1'b0, IW'(restore_fault - head_q)} + 1'b1;
    end else begin
      if (push) tail_q <= tail_q + 1'b1;
      if (pop)  head_q <= head_q + 1'b1;
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head  = head_q;
  assign tail  = tail_q;
  assign full  = (cnt_q == (IW+1)'(DEPTH));
  assign empty = (cnt_q == '0);
endmodule

// File: rtl/rob_walker.sv
module rob_walker
  import rob_pkg::*;
#(
  parameter int DEPTH = ROB_DEPTH,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IW-1:0]     start_fault,
  input  logic [IW-1:0]     tail,
  input  rob_payload_t      ent,
  input  logic [PR_W-1:0]   lk_prev_pr,
  input  logic              lk_prev_bound,
  input  logic [PR_W-1:0]   lk_own_pr,
  input  logic              lk_own_bound,
  output logic              busy,
  output logic              finish,
  output logic [IW-1:0]     walk_ptr,
  output logic [IW-1:0]     fault_idx,
  output logic              rb_valid,
  output logic [LREG_W-1:0] rb_lreg,
  output logic [VPR_W-1:0]  rb_map_vpr,
  output logic [PR_W-1:0]   rb_map_pr,
  output logic              rb_map_bound,
  output logic [VPR_W-1:0]  rb_free_vpr,
  output logic [PR_W-1:0]   rb_free_pr,
  output logic              rb_free_pr_valid
);
  walk_state_t   st_q;
  logic [IW-1:0] ptr_q, fault_q;
  logic          undo_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= WALK_IDLE;
      ptr_q   <= '0;
      fault_q <= '0;
    end else begin
      case (st_q)
        WALK_IDLE: if (start) begin
          st_q    <= WALK_RUN;
          ptr_q   <= tail - 1'b1;
          fault_q <= start_fault;
        end
        WALK_RUN: begin
          if (ptr_q == fault_q) st_q <= WALK_IDLE;
          else                  ptr_q <= ptr_q - 1'b1;
        end
        default: st_q <= WALK_IDLE;
      endcase
    end
  end

  assign busy      = (st_q == WALK_RUN);
  assign finish    = busy && (ptr_q == fault_q);
  assign undo_act  = busy && (ptr_q != fault_q);
  assign walk_ptr  = ptr_q;
  assign fault_idx = fault_q;

  assign rb_valid         = undo_act && ent.has_dst;
  assign rb_lreg          = ent.lreg;
  assign rb_map_vpr       = ent.prev_vpr;
  assign rb_map_pr        = lk_prev_pr;
  assign rb_map_bound     = lk_prev_bound;
  assign rb_free_vpr      = ent.own_vpr;
  assign rb_free_pr       = lk_own_pr;
  assign rb_free_pr_valid = rb_valid && lk_own_bound;
endmodule

// File: rtl/rob_rollback.sv
module rob_rollback
  import rob_pkg::*;
#(
  parameter int DEPTH = ROB_DEPTH,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  output logic              alloc_ready,
  input  logic              alloc_has_dst,
  input  logic [LREG_W-1:0] alloc_lreg,
  input  logic [VPR_W-1:0]  alloc_prev_vpr,
  input  logic [VPR_W-1:0]  alloc_own_vpr,
  output logic [IW-1:0]     alloc_idx,
  input  logic              cmpl_valid,
  input  logic [IW-1:0]     cmpl_idx,
  input  logic              cmpl_exc,
  output logic              commit_valid,
  input  logic              commit_ready,
  output logic              commit_has_dst,
  output logic [VPR_W-1:0]  commit_prev_vpr,
  input  logic              rec_valid,
  input  logic [IW-1:0]     rec_idx,
  output logic              busy,
  output logic              full,
  output logic              empty,
  output logic [VPR_W-1:0]  lk_prev_vpr,
  input  logic [PR_W-1:0]   lk_prev_pr,
  input  logic              lk_prev_bound,
  output logic [VPR_W-1:0]  lk_own_vpr,
  input  logic [PR_W-1:0]   lk_own_pr,
  input  logic              lk_own_bound,
  output logic              rb_valid,
  output logic [LREG_W-1:0] rb_lreg,
  output logic [VPR_W-1:0]  rb_map_vpr,
  output logic [PR_W-1:0]   rb_map_pr,
  output logic              rb_map_bound,
  output logic [VPR_W-1:0]  rb_free_vpr,
  output logic [PR_W-1:0]   rb_free_pr,
  output logic              rb_free_pr_valid
);
  logic [IW-1:0] head, tail, walk_ptr, fault_idx, start_fault;
  logic          push, pop, finish, head_exc, rec_start;
  logic          h_done, h_exc;
  rob_payload_t  wr_data, head_ent, walk_ent;

  assign wr_data = '{has_dst:  alloc_has_dst, lreg: alloc_lreg,
                     prev_vpr: alloc_prev_vpr, own_vpr: alloc_own_vpr};

  // oldest slot faulted: recover on it instead of retiring it
  assign head_exc    = !busy && !empty && h_done && h_exc;
  assign rec_start   = !busy && (rec_valid || head_exc);
  assign start_fault = rec_valid ? rec_idx : head;

  assign alloc_ready  = !busy && !full && !rec_start;
  assign push         = alloc_valid && alloc_ready;
  assign commit_valid = !busy && !rec_start && !empty && h_done && !h_exc;
  assign pop          = commit_valid && commit_ready;
  assign alloc_idx    = tail;

  assign commit_has_dst  = head_ent.has_dst;
  assign commit_prev_vpr = head_ent.prev_vpr;
  assign lk_prev_vpr     = walk_ent.prev_vpr;
  assign lk_own_vpr      = walk_ent.own_vpr;

  rob_entry_store #(.DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (push),
    .wr_idx    (tail),
    .wr_data   (wr_data),
    .set_en    (cmpl_valid),
    .set_idx   (cmpl_idx),
    .set_exc   (cmpl_exc),
    .clr_en    (finish),
    .clr_idx   (fault_idx),
    .rd_a_idx  (head),
    .rd_a_data (head_ent),
    .rd_a_done (h_done),
    .rd_a_exc  (h_exc),
    .rd_b_idx  (walk_ptr),
    .rd_b_data (walk_ent)
  );

  rob_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk           (clk),
    .rst_n         (rst_n),
    .push          (push),
    .pop           (pop),
    .restore_en    (finish),
    .restore_fault (fault_idx),
    .head          (head),
    .tail          (tail),
    .full          (full),
    .empty         (empty)
  );

  rob_walker #(.DEPTH(DEPTH)) u_walk (
    .clk              (clk),
    .rst_n            (rst_n),
    .start            (rec_start),
    .start_fault      (start_fault),
    .tail             (tail),
    .ent              (walk_ent),
    .lk_prev_pr       (lk_prev_pr),
    .lk_prev_bound    (lk_prev_bound),
    .lk_own_pr        (lk_own_pr),
    .lk_own_bound     (lk_own_bound),
    .busy             (busy),
    .finish           (finish),
    .walk_ptr         (walk_ptr),
    .fault_idx        (fault_idx),
    .rb_valid         (rb_valid),
    .rb_lreg          (rb_lreg),
    .rb_map_vpr       (rb_map_vpr),
    .rb_map_pr        (rb_map_pr),
    .rb_map_bound     (rb_map_bound),
    .rb_free_vpr      (rb_free_vpr),
    .rb_free_pr       (rb_free_pr),
    .rb_free_pr_valid (rb_free_pr_valid)
  );
endmodule

// File: rtl/rob_rollback_chk.sv
module rob_rollback_chk
  import rob_pkg::*;
#(
  parameter int IW = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alloc_ready,
  input logic             commit_valid,
  input logic             commit_ready,
  input logic             commit_has_dst,
  input logic [VPR_W-1:0] commit_prev_vpr,
  input logic             rec_valid,
  input logic             busy,
  input logic             full,
  input logic             empty,
  input logic             rb_valid,
  input logic             rb_free_pr_valid,
  input logic [IW-1:0]    walk_ptr,
  input logic [IW-1:0]    fault_idx
);
  // R1
  full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  // R2
  full_blocks_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !alloc_ready);

  // R3
  empty_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !commit_valid);

  // R4
  commit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_valid && !commit_ready) |=> (busy || rec_valid ||
      (commit_valid && $stable(commit_prev_vpr) && $stable(commit_has_dst))));

  // R5
  rec_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && rec_valid) |=> busy);

  // R5
  busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!alloc_ready && !commit_valid));

  // R6
  walk_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && walk_ptr != fault_idx) |=>
      (busy && walk_ptr == IW'($past(walk_ptr) - 1'b1)));

  // R6
  walk_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && walk_ptr == fault_idx) |=> !busy);

  // R7
  rb_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rb_valid |-> busy);

  // R8
  free_pr_with_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rb_free_pr_valid |-> rb_valid);
endmodule

bind rob_rollback rob_rollback_chk #(.IW(IW)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .alloc_ready      (alloc_ready),
  .commit_valid     (commit_valid),
  .commit_ready     (commit_ready),
  .commit_has_dst   (commit_has_dst),
  .commit_prev_vpr  (commit_prev_vpr),
  .rec_valid        (rec_valid),
  .busy             (busy),
  .full             (full),
  .empty            (empty),
  .rb_valid         (rb_valid),
  .rb_free_pr_valid (rb_free_pr_valid),
  .walk_ptr         (walk_ptr),
  .fault_idx        (fault_idx)
);

// File: tb/rob_rollback_tb.sv
module rob_rollback_tb;
  import rob_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int D = 16;

  logic clk = 0, rst_n = 0;
  logic alloc_valid = 0, alloc_ready, alloc_has_dst = 0;
  logic [LREG_W-1:0] alloc_lreg = 0;
  logic [VPR_W-1:0]  alloc_prev_vpr = 0, alloc_own_vpr = 0;
  logic [3:0] alloc_idx;
  logic cmpl_valid = 0, cmpl_exc = 0;
  logic [3:0] cmpl_idx = 0;
  logic commit_valid, commit_ready = 0, commit_has_dst;
  logic [VPR_W-1:0] commit_prev_vpr;
  logic rec_valid = 0;
  logic [3:0] rec_idx = 0;
  logic busy, full, empty;
  logic [VPR_W-1:0] lk_prev_vpr, lk_own_vpr;
  logic [PR_W-1:0]  lk_prev_pr, lk_own_pr;
  logic lk_prev_bound, lk_own_bound;
  logic rb_valid, rb_map_bound, rb_free_pr_valid;
  logic [LREG_W-1:0] rb_lreg;
  logic [VPR_W-1:0]  rb_map_vpr, rb_free_vpr;
  logic [PR_W-1:0]   rb_map_pr, rb_free_pr;

  always #(CLK_PERIOD/2) clk = ~clk;

  // tag-to-register table stand-in
  function automatic logic [PR_W-1:0] pmt_pr(input logic [VPR_W-1:0] v);
    return PR_W'(v * 3);
  endfunction
  function automatic logic pmt_bound(input logic [VPR_W-1:0] v);
    return ^v;
  endfunction
  assign lk_prev_pr    = pmt_pr(lk_prev_vpr);
  assign lk_prev_bound = pmt_bound(lk_prev_vpr);
  assign lk_own_pr     = pmt_pr(lk_own_vpr);
  assign lk_own_bound  = pmt_bound(lk_own_vpr);

  rob_rollback u_dut (.*);

  // reference model
  int m_head, m_cnt, m_wptr, m_fault;
  bit m_busy;
  int m_lreg[D], m_prev[D], m_own[D];
  bit m_dst[D], m_done[D], m_exc[D];
  bit e_push, e_pop, e_rs;
  int n_chk, n_fail;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_outputs();
    int tail = (m_head + m_cnt) % D;
    bit hx   = !m_busy && m_cnt > 0 && m_done[m_head] && m_exc[m_head];
    bit cv;
    bit rv;
    e_rs   = !m_busy && (rec_valid || hx);
    cv     = !m_busy && !e_rs && m_cnt > 0 && m_done[m_head] && !m_exc[m_head];
    e_push = alloc_valid && !m_busy && m_cnt < D && !e_rs;
    e_pop  = cv && commit_ready;
    rv     = m_busy && m_wptr != m_fault && m_dst[m_wptr];
    chk("R1", "empty", int'(empty), int'(m_cnt == 0));
    chk("R2", "full", int'(full), int'(m_cnt == D));
    chk("R2", "alloc_ready", int'(alloc_ready), int'(!m_busy && m_cnt < D && !e_rs));
    chk("R9", "alloc_idx", int'(alloc_idx), tail);
    chk("R5", "busy", int'(busy), int'(m_busy));
    chk("R3", "commit_valid", int'(commit_valid), int'(cv));
    if (cv) begin
      chk("R3", "commit_has_dst", int'(commit_has_dst), int'(m_dst[m_head]));
      chk("R3", "commit_prev_vpr", int'(commit_prev_vpr), m_prev[m_head]);
    end
    chk("R8", "rb_valid", int'(rb_valid), int'(rv));
    if (rv) begin
      chk("R7", "rb_lreg", int'(rb_lreg), m_lreg[m_wptr]);
      chk("R7", "rb_map_vpr", int'(rb_map_vpr), m_prev[m_wptr]);
      chk("R7", "rb_map_pr", int'(rb_map_pr), int'(pmt_pr(VPR_W'(m_prev[m_wptr]))));
      chk("R7", "rb_map_bound", int'(rb_map_bound), int'(pmt_bound(VPR_W'(m_prev[m_wptr]))));
      chk("R7", "rb_free_vpr", int'(rb_free_vpr), m_own[m_wptr]);
      chk("R7", "rb_free_pr", int'(rb_free_pr), int'(pmt_pr(VPR_W'(m_own[m_wptr]))));
      chk("R7", "rb_free_pr_valid", int'(rb_free_pr_valid),
          int'(pmt_bound(VPR_W'(m_own[m_wptr]))));
    end else begin
      chk("R8", "rb_free_pr_valid", int'(rb_free_pr_valid), 0);
    end
  endtask

  task automatic update_model();
    int tail = (m_head + m_cnt) % D;
    if (cmpl_valid) begin  // R12
      m_done[cmpl_idx] = 1;
      m_exc[cmpl_idx]  = cmpl_exc;
    end
    if (m_busy) begin
      if (m_wptr == m_fault) begin  // R9 R10
        m_busy = 0;
        m_cnt  = ((m_fault - m_head + D) % D) + 1;
        m_exc[m_fault] = 0;
      end else m_wptr = (m_wptr + D - 1) % D;  // R6
    end else if (e_rs) begin  // R11: only starts when idle
      m_busy  = 1;
      m_fault = rec_valid ? int'(rec_idx) : m_head;
      m_wptr  = (tail + D - 1) % D;
    end else begin
      if (e_push) begin
        m_lreg[tail] = alloc_lreg; m_prev[tail] = alloc_prev_vpr;
        m_own[tail]  = alloc_own_vpr; m_dst[tail] = alloc_has_dst;
        m_done[tail] = 0; m_exc[tail] = 0;
      end
      if (e_pop) m_head = (m_head + 1) % D;
      m_cnt = m_cnt + int'(e_push) - int'(e_pop);
    end
  endtask

  task automatic tick();
    #1 check_outputs();
    @(posedge clk);
    update_model();
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    alloc_valid = 0; cmpl_valid = 0; cmpl_exc = 0; rec_valid = 0; commit_ready = 0;
  endtask

  task automatic rand_payload();
    alloc_has_dst  = ($urandom % 4) != 0;
    alloc_lreg     = LREG_W'($urandom);
    alloc_prev_vpr = VPR_W'($urandom);
    alloc_own_vpr  = VPR_W'($urandom);
  endtask

  // one random cycle with given percentages
  task automatic rand_cycle(input int p_alloc, input int p_cr, input int p_cmpl,
                            input int p_rec, input int p_exc);
    idle_inputs();
    rand_payload();
    alloc_valid  = ($urandom % 100) < p_alloc;
    commit_ready = ($urandom % 100) < p_cr;
    if (!m_busy && m_cnt > 0 && ($urandom % 100) < p_cmpl) begin
      int idx = (m_head + int'($urandom % m_cnt)) % D;
      if (!m_done[idx]) begin
        cmpl_valid = 1; cmpl_idx = 4'(idx);
        cmpl_exc = ($urandom % 100) < p_exc;
      end
    end
    if (m_cnt > 0 && ($urandom % 100) < p_rec) begin  // R11 when busy
      rec_valid = 1;
      rec_idx   = 4'((m_head + int'($urandom % m_cnt)) % D);
    end
    tick();
  endtask

  initial begin
    m_head = 0; m_cnt = 0; m_busy = 0; m_wptr = 0; m_fault = 0;
    n_chk = 0; n_fail = 0;
    for (int i = 0; i < D; i++) begin m_done[i] = 0; m_exc[i] = 0; m_dst[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();  // R1 reset state
    // R2 fill to full, keep offering
    for (int i = 0; i < 20; i++) begin
      idle_inputs(); rand_payload(); alloc_valid = 1; tick();
    end
    // R6 misprediction in the middle
    idle_inputs(); rec_valid = 1; rec_idx = 4'd5; tick();
    for (int i = 0; i < 12; i++) begin idle_inputs(); tick(); end
    // R10 exception on the oldest slot, commits blocked
    idle_inputs(); cmpl_valid = 1; cmpl_idx = 4'd0; cmpl_exc = 1; tick();
    for (int i = 0; i < 10; i++) begin idle_inputs(); tick(); end
    idle_inputs(); commit_ready = 1; tick();
    // R9 recovery on the youngest slot
    for (int i = 0; i < 6; i++) begin idle_inputs(); rand_payload(); alloc_valid = 1; tick(); end
    idle_inputs(); rec_valid = 1; rec_idx = 4'((m_head + m_cnt - 1) % D); tick();
    for (int i = 0; i < 4; i++) begin idle_inputs(); tick(); end
    // randomised phases: R3 R4 back-pressure, R5 R11
    for (int i = 0; i < 2000; i++) rand_cycle(70, 50, 40, 3, 5);
    for (int i = 0; i < 2000; i++) rand_cycle(90, 20, 60, 6, 10);
    for (int i = 0; i < 1000; i++) rand_cycle(30, 90, 80, 2, 3);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule